// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the two vector configuration instructions of a vector-capable core: one takes the requested element type from an 11-bit immediate, the other from a source register. Each cycle it looks at one instruction word together with the two source operand values read from the register file. When the word is a configuration instruction, the block checks whether the requested type is legal. It then works out the largest vector length that the hardware vector size allows for that element width and register grouping. The granted length is returned for the destination register in the same cycle. The length, type and start-index registers take their new values at the next clock edge.

The block also exports a compact status word that later decode stages use: an illegal flag, the element width code, the grouping code and a flag that says the whole maximum length is active. After the register-sourced form it raises a one-cycle flush request. The new type of that form is not known at decode time, so instructions already decoded under the old type have to be decoded again. The immediate form never flushes, because its type is fixed in the instruction word.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vtype holds only bit XLEN-2 (the illegal flag) set, vl and vstart are 0 and flush_req is 0.
- R2: A word is the immediate form when bits 6:0 are 1010111, bits 14:12 are 111 and bit 31 is 0; its requested type is bits 30:20 zero-extended. It is the register form when bits 6:0 are 1010111, bits 14:12 are 111 and bits 31:25 are 1000000; its requested type is rs2_val. Any other word, or a word without instr_valid, gives rd_we = 0 and leaves vl, vtype and vstart unchanged.
- R3: For a legal type, with vlmul in bits 1:0 and vsew in bits 4:2, the maximum length is VLEN >> (vsew + 3 - vlmul). The new vl is the smaller of the requested length and that maximum, vtype takes the requested value, and vstart becomes 0.
- R4: For an accepted instruction, rd_we is 1 in the same cycle, rd_idx equals instruction bits 11:7, and rd_data equals the vl that is about to be written (0 for an illegal type).
- R5: The type is illegal when 8 << vsew exceeds ELEN, when bit XLEN-2 is set, when bits 6:5 are nonzero, when any bit from 7 to XLEN-3 is set, or when bit XLEN-1 is set. In that case vtype becomes only bit XLEN-2 set, and vl and vstart become 0.
- R6: When the rs1 field (bits 19:15) is 0, the requested length is AVL_INF (512), whatever rs1_val holds. Otherwise it is rs1_val.
- R7: flush_req is 1 for exactly the cycle after a register-form instruction is accepted. It is 0 after an immediate-form instruction, and 0 when no instruction is accepted.
- R8: With vec_en = 1, status bit 8 is the vtype illegal flag, bits 7:5 are vsew, bits 4:3 are vlmul, bit 2 is 1 only when vstart = 0 and vl equals the maximum length of the current vtype, and bits 1:0 are 0.
- R9: With vec_en = 0, the status word is 9'h100 (only the illegal flag set), whatever the stored state is.
- R10: vl, vtype and vstart change only at the clock edge that ends the cycle in which a configuration instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_en | input | 1 | Vector extension enabled |
| instr_valid | input | 1 | instr holds an instruction this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of source register rs1 (requested length) |
| rs2_val | input | XLEN | Value of source register rs2 (register-form type) |
| rd_we | output | 1 | Write the granted length to the destination register |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Granted vector length |
| vl | output | XLEN | Current vector length |
| vtype | output | XLEN | Current vector type |
| vstart | output | XLEN | Current start element index |
| flush_req | output | 1 | One-cycle front-end flush request |
| status | output | 9 | Packed configuration status for downstream decode |

## Verification
A wrong stored vtype or vl cannot stay hidden. It shows on the vtype and vl ports one cycle after the configuring instruction, and it shows in the status fields and full-length flag in that same cycle. A wrong grant, or a missed legality rule, shows at once on rd_data in the cycle the instruction is presented. A mis-timed or missing flush shows on flush_req in the following cycle. The random mix compares every one of these against a bench model after every instruction, and directed cases cover each illegal cause, the unbounded request, ignored words and a disabled extension.

// File: rtl/vcfg_pkg.sv
// Package: shared encodings for the vector configuration unit.
// Assumes standard 32-bit instruction encoding with the major opcode in bits 6:0.
package vcfg_pkg;
    localparam logic [6:0] OPC_VCFG   = 7'b1010111;
    localparam logic [2:0] F3_VCFG    = 3'b111;
    localparam logic [6:0] F7_REGFORM = 7'b1000000;
    localparam int         STATUS_W   = 9;

    typedef enum logic [1:0] {
        CFG_NONE = 2'd0,
        CFG_IMM  = 2'd1,
        CFG_REG  = 2'd2
    } cfg_kind_e;
endpackage

// File: rtl/vcfg_decode.sv
// Module: vcfg_decode
// Recognises the two configuration forms and splits out their fields.
// Assumes instr is stable for the whole cycle in which instr_valid is high.
module vcfg_decode
    import vcfg_pkg::*;
(
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output cfg_kind_e   kind,
    output logic [4:0]  rs1_idx,
    output logic [4:0]  rd_idx,
    output logic [10:0] imm_vtype
);
    // Match opcode and funct3, then split the forms on the top bits
    always_comb begin
        kind = CFG_NONE;
        if (instr_valid && instr[6:0] == OPC_VCFG && instr[14:12] == F3_VCFG) begin
            if (!instr[31])
                kind = CFG_IMM;
            else if (instr[31:25] == F7_REGFORM)
                kind = CFG_REG;
        end
    end

    // Field extraction, independent of the match result
    always_comb begin
        rs1_idx   = instr[19:15];
        rd_idx    = instr[11:7];
        imm_vtype = instr[30:20];
    end
endmodule

// File: rtl/vcfg_vlmax.sv
// Module: vcfg_vlmax
// Maximum vector length for one element width and grouping code.
// Assumes vsew + 3 >= vlmul, which always holds for a 3-bit vsew and a 2-bit vlmul.
module vcfg_vlmax #(
    parameter int XLEN = 32,
    parameter int VLEN = 128
) (
    input  logic [2:0]      vsew,
    input  logic [1:0]      vlmul,
    output logic [XLEN-1:0] vlmax
);
    localparam logic [XLEN-1:0] VLEN_W = XLEN'(VLEN);

    logic [4:0] shamt;

    // One right shift replaces the scaled divide
    always_comb begin
        shamt = 5'(vsew) + 5'd3 - 5'(vlmul);
        vlmax = VLEN_W >> shamt;
    end
endmodule

// File: rtl/vcfg_grant.sv
// Module: vcfg_grant
// Checks a requested type for legality and computes the granted length and next vtype.
// Assumes vlmax was derived from the same requested type.
module vcfg_grant #(
    parameter int XLEN    = 32,
    parameter int ELEN    = 64,
    parameter int AVL_INF = 512
) (
    input  logic [XLEN-1:0] req_vtype,
    input  logic            rs1_is_x0,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] vlmax,
    output logic            illegal,
    output logic [XLEN-1:0] grant_vl,
    output logic [XLEN-1:0] next_vtype
);
    localparam int              ILL_BIT = XLEN - 2;
    localparam logic [XLEN-1:0] ILL_VTYPE = XLEN'(1) << ILL_BIT;

    logic            sew_too_wide;
    logic [XLEN-1:0] avl;

    // Collect every cause that makes the type illegal
    always_comb begin
        sew_too_wide = (32'd8 << req_vtype[4:2]) > 32'(ELEN);
        illegal = sew_too_wide
                | req_vtype[ILL_BIT]
                | (|req_vtype[6:5])
                | (|req_vtype[XLEN-3:7])
                | req_vtype[XLEN-1];
    end

    // Clamp the requested length and choose the next type
    always_comb begin
        avl = rs1_is_x0 ? XLEN'(AVL_INF) : rs1_val;
        if (illegal) begin
            grant_vl   = '0;
            next_vtype = ILL_VTYPE;
        end else begin
            grant_vl   = (avl < vlmax) ? avl : vlmax;
            next_vtype = req_vtype;
        end
    end
endmodule

// File: rtl/vcfg_status.sv
// Module: vcfg_status
// Packs the current configuration into the status word for downstream decode.
// Assumes vlmax_cur was derived from the stored vtype.
module vcfg_status
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                vec_en,
    input  logic                ill_q,
    input  logic [2:0]          vsew_q,
    input  logic [1:0]          vlmul_q,
    input  logic [XLEN-1:0]     vl_q,
    input  logic [XLEN-1:0]     vstart_q,
    input  logic [XLEN-1:0]     vlmax_cur,
    output logic [STATUS_W-1:0] status
);
    logic full;

    // Full flag, then the packed word or the disabled pattern
    always_comb begin
        full = (vstart_q == '0) && (vl_q == vlmax_cur);
        if (!vec_en)
            status = STATUS_W'(9'h100);
        else
            status = {ill_q, vsew_q, vlmul_q, full, 2'b00};
    end
endmodule

// File: rtl/vcfg_unit.sv
// Module: vcfg_unit (top)
// Executes the vector configuration instructions in one cycle and holds vl, vtype and vstart.
// Assumes the register file discards writes to x0 and acts on rd_we in the same cycle.
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int VLEN    = 128,
    parameter int ELEN    = 64,
    parameter int AVL_INF = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vec_en,
    input  logic                instr_valid,
    input  logic [31:0]         instr,
    input  logic [XLEN-1:0]     rs1_val,
    input  logic [XLEN-1:0]     rs2_val,
    output logic                rd_we,
    output logic [4:0]          rd_idx,
    output logic [XLEN-1:0]     rd_data,
    output logic [XLEN-1:0]     vl,
    output logic [XLEN-1:0]     vtype,
    output logic [XLEN-1:0]     vstart,
    output logic                flush_req,
    output logic [STATUS_W-1:0] status
);
    localparam int              ILL_BIT   = XLEN - 2;
    localparam logic [XLEN-1:0] ILL_VTYPE = XLEN'(1) << ILL_BIT;

    cfg_kind_e       kind;
    logic [4:0]      rs1_idx;
    logic [10:0]     imm_vtype;
    logic [XLEN-1:0] req_vtype;
    logic [XLEN-1:0] vlmax_req;
    logic [XLEN-1:0] vlmax_cur;
    logic            illegal;
    logic [XLEN-1:0] grant_vl;
    logic [XLEN-1:0] next_vtype;
    logic            cfg_acc;
    logic [XLEN-1:0] vl_q, vtype_q, vstart_q;
    logic            flush_q;

    vcfg_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .kind        (kind),
        .rs1_idx     (rs1_idx),
        .rd_idx      (rd_idx),
        .imm_vtype   (imm_vtype)
    );

    // Requested type comes from the immediate or from rs2
    always_comb begin
        req_vtype = (kind == CFG_REG) ? rs2_val : XLEN'(imm_vtype);
        cfg_acc   = (kind != CFG_NONE);
    end

    vcfg_vlmax #(.XLEN(XLEN), .VLEN(VLEN)) u_vlmax_req (
        .vsew  (req_vtype[4:2]),
        .vlmul (req_vtype[1:0]),
        .vlmax (vlmax_req)
    );

    vcfg_grant #(.XLEN(XLEN), .ELEN(ELEN), .AVL_INF(AVL_INF)) u_grant (
        .req_vtype  (req_vtype),
        .rs1_is_x0  (rs1_idx == 5'd0),
        .rs1_val    (rs1_val),
        .vlmax      (vlmax_req),
        .illegal    (illegal),
        .grant_vl   (grant_vl),
        .next_vtype (next_vtype)
    );

    // Same-cycle destination write of the granted length
    always_comb begin
        rd_we   = cfg_acc;
        rd_data = grant_vl;
    end

    // Architectural configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtype_q  <= ILL_VTYPE;
            vl_q     <= '0;
            vstart_q <= '0;
        end else if (cfg_acc) begin
            vtype_q  <= next_vtype;
            vl_q     <= grant_vl;
            vstart_q <= '0;
        end
    end

    // One-cycle flush after the register-sourced form only
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_q <= 1'b0;
        else
            flush_q <= (kind == CFG_REG);
    end

    vcfg_vlmax #(.XLEN(XLEN), .VLEN(VLEN)) u_vlmax_cur (
        .vsew  (vtype_q[4:2]),
        .vlmul (vtype_q[1:0]),
        .vlmax (vlmax_cur)
    );

    vcfg_status #(.XLEN(XLEN)) u_status (
        .vec_en    (vec_en),
        .ill_q     (vtype_q[ILL_BIT]),
        .vsew_q    (vtype_q[4:2]),
        .vlmul_q   (vtype_q[1:0]),
        .vl_q      (vl_q),
        .vstart_q  (vstart_q),
        .vlmax_cur (vlmax_cur),
        .status    (status)
    );

    always_comb begin
        vl        = vl_q;
        vtype     = vtype_q;
        vstart    = vstart_q;
        flush_req = flush_q;
    end

    // R3: a legal stored type never carries a length above its maximum
    assert_vl_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vtype_q[ILL_BIT] |-> (vl_q <= vlmax_cur));

    // R5: the illegal state is the single canonical pattern with zero length
    assert_ill_canon_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vtype_q[ILL_BIT] |-> (vl_q == '0 && vtype_q == ILL_VTYPE));

    // R4: the value written to rd is the length held afterwards
    assert_rd_is_vl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_acc |=> (vl_q == $past(rd_data)));

    // R7: the immediate form never requests a flush
    assert_imm_noflush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CFG_IMM) |=> !flush_req);

    // R10: with nothing accepted, configuration state holds
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_acc |=> ($stable(vl_q) && $stable(vtype_q) && $stable(vstart_q)));
endmodule

// File: tb/sim_vcfg_unit.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random configuration instructions,
// compared against a model written from the requirements.
module sim_vcfg_unit;
    localparam int XLEN = 32;
    localparam int VLEN = 128;
    localparam int ELEN = 64;
    localparam int AVLI = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_en = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        rd_we;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data, vl, vtype, vstart;
    logic        flush_req;
    logic [8:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_vtype, m_vl;
    logic        m_flush;

    always #2.5 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .AVL_INF(AVLI)) u0 (
        .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .instr_valid(instr_valid),
        .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val), .rd_we(rd_we),
        .rd_idx(rd_idx), .rd_data(rd_data), .vl(vl), .vtype(vtype),
        .vstart(vstart), .flush_req(flush_req), .status(status)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // 0 none, 1 immediate form, 2 register form (R2)
    function automatic int kind_of(input logic [31:0] w, input bit v);
        if (!v || w[6:0] != 7'b1010111 || w[14:12] != 3'b111) return 0;
        if (!w[31]) return 1;
        if (w[31:25] == 7'b1000000) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] vlmax_of(input logic [31:0] t);
        int sh;
        sh = int'(t[4:2]) + 3 - int'(t[1:0]);
        return 32'(VLEN) >> sh;
    endfunction

    function automatic bit illegal_of(input logic [31:0] t);
        return ((8 << t[4:2]) > ELEN) || t[30] || (t[6:5] != 0) || (t[29:7] != 0) || t[31];
    endfunction

    function automatic logic [8:0] status_of(input logic [31:0] t, input logic [31:0] l, input bit en);
        if (!en) return 9'h100;
        return {t[30], t[4:2], t[1:0], (l == vlmax_of(t)), 2'b00};
    endfunction

    function automatic logic [31:0] imm_word(input logic [10:0] z, input logic [4:0] s1, input logic [4:0] d);
        return {1'b0, z, s1, 3'b111, d, 7'b1010111};
    endfunction

    function automatic logic [31:0] reg_word(input logic [4:0] s2, input logic [4:0] s1, input logic [4:0] d);
        return {7'b1000000, s2, s1, 3'b111, d, 7'b1010111};
    endfunction

    task automatic check_state(input string tag);
        chk(vl == m_vl, "R3/R10", {tag, " vl"}, vl, m_vl);
        chk(vtype == m_vtype, "R5/R10", {tag, " vtype"}, vtype, m_vtype);
        chk(vstart == 32'd0, "R3", {tag, " vstart"}, vstart, 32'd0);
        chk(flush_req == m_flush, "R7", {tag, " flush"}, 32'(flush_req), 32'(m_flush));
        chk(status == status_of(m_vtype, m_vl, vec_en), vec_en ? "R8" : "R9",
            {tag, " status"}, 32'(status), 32'(status_of(m_vtype, m_vl, vec_en)));
    endtask

    // Present one word for one cycle, check the result, then the new state
    task automatic step(input logic [31:0] w, input bit v, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        int k;
        logic [31:0] req, avl, gvl, nvt;
        @(negedge clk);
        instr = w; instr_valid = v; rs1_val = a; rs2_val = b;
        k = kind_of(w, v);
        req = (k == 2) ? b : {21'd0, w[30:20]};
        avl = (w[19:15] == 5'd0) ? 32'(AVLI) : a;       // R6
        if (illegal_of(req)) begin
            gvl = 32'd0; nvt = 32'h4000_0000;            // R5
        end else begin
            gvl = (avl < vlmax_of(req)) ? avl : vlmax_of(req);
            nvt = req;
        end
        #1;
        chk(rd_we == (k != 0), "R2/R4", {tag, " rd_we"}, 32'(rd_we), 32'(k != 0));
        if (k != 0) begin
            chk(rd_data == gvl, "R4", {tag, " rd_data"}, rd_data, gvl);
            chk(rd_idx == w[11:7], "R4", {tag, " rd_idx"}, 32'(rd_idx), 32'(w[11:7]));
        end
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
        if (k != 0) begin m_vl = gvl; m_vtype = nvt; end
        m_flush = (k == 2);
        check_state(tag);
    endtask

    initial begin
        logic [31:0] t, w, a;
        void'($urandom(32'd7321));
        m_vtype = 32'h4000_0000; m_vl = 0; m_flush = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(vtype == 32'h4000_0000, "R1", "reset vtype", vtype, 32'h4000_0000);
        chk(vl == 0 && vstart == 0, "R1", "reset vl/vstart", vl | vstart, 0);
        chk(flush_req == 1'b0, "R1", "reset flush", 32'(flush_req), 0);
        chk(status == 9'h100, "R1/R8", "reset status", 32'(status), 32'h100);

        // R6: x0 requests unbounded length: e8, m8 -> VLEN
        step(imm_word(11'h003, 5'd0, 5'd3), 1, 32'd5, 0, "R6 imm e8m8 x0");
        // R3 clamp: e64, m1 -> maximum 2, ask 5
        step(imm_word(11'h00C, 5'd4, 5'd9), 1, 32'd5, 0, "R3 e64m1 clamp");
        // R3 below max: e16 m2, ask 7 (full flag off, R8)
        step(imm_word(11'h005, 5'd4, 5'd1), 1, 32'd7, 0, "R3 e16m2 ask7");
        // R7 register form, vediv nonzero -> illegal (R5)
        step(reg_word(5'd2, 5'd4, 5'd1), 1, 32'd7, 32'h0000_0020, "R5 ediv");
        step(32'h0000_0013, 0, 0, 0, "R7 idle after reg");
        step(reg_word(5'd2, 5'd4, 5'd1), 1, 32'd9, 32'h0000_0009, "R7 reg e32m2");
        step(reg_word(5'd2, 5'd4, 5'd1), 1, 32'd9, 32'h8000_0000, "R5 top bit");
        step(reg_word(5'd2, 5'd4, 5'd1), 1, 32'd9, 32'h4000_0000, "R5 ill bit");
        step(reg_word(5'd2, 5'd4, 5'd1), 1, 32'd9, 32'h0000_0080, "R5 reserved");
        step(imm_word(11'h010, 5'd4, 5'd1), 1, 32'd9, 0, "R5 sew128");
        step(imm_word(11'h00A, 5'd0, 5'd1), 1, 0, 0, "R8 full e32m4");
        // R2: ignored words keep state
        step(imm_word(11'h000, 5'd1, 5'd1) ^ 32'h0000_0001, 1, 3, 0, "R2 bad opcode");
        step(reg_word(5'd1, 5'd1, 5'd1) ^ 32'h0200_0000, 1, 3, 0, "R2 bad funct7");
        step(imm_word(11'h000, 5'd1, 5'd1), 0, 3, 0, "R2 not valid");
        // R9 extension disabled
        vec_en = 1'b0;
        step(imm_word(11'h000, 5'd1, 5'd1), 1, 3, 0, "R9 disabled");
        vec_en = 1'b1;

        for (int i = 0; i < 600; i++) begin
            t = {27'd0, 5'($urandom)};
            if ($urandom % 8 == 0) t[5 + ($urandom % 27)] = 1'b1;
            a = ($urandom % 4 == 0) ? $urandom : ($urandom % 300);
            case ($urandom % 4)
                0: w = imm_word(t[10:0], 5'($urandom), 5'($urandom));
                1: w = reg_word(5'($urandom), 5'($urandom), 5'($urandom));
                2: w = imm_word(t[10:0], 5'd0, 5'($urandom));
                default: w = $urandom;
            endcase
            if ($urandom % 16 == 0) vec_en = ~vec_en;
            step(w, ($urandom % 8) != 0, a, t, "rand R2-mix");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule